// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a two-wire serial slave that lets an external bus master read and write a small file of byte-wide registers. SCL and SDA come from the pads as plain inputs. SDA is open drain, so the block drives it with a constant-low data output and an output enable. Both bus lines pass through a synchronizer clocked by the system clock. START, STOP and the SCL edges are all detected from the synchronized samples.

The 7-bit device address has a fixed upper nibble. Its three low bits come from strap pins. The top strap bit is captured while reset is held and does not change after that. A write transaction first loads an 8-bit register pointer. Bit 7 of the pointer enables auto-increment and bits 6:0 select the register. Later data bytes go to the selected register. A read transaction returns the selected register, most significant bit first, and keeps sending bytes until the master answers with NACK. Each register write also appears on a one-cycle strobe output, which carries the index and the data.

Top module: `i2c_regport`

## Requirements
- R1: The slave responds to address {0010b, A2, A1, A0}, where bit 0 of the first byte after START is the direction bit (0 = write, 1 = read). On a match the slave pulls SDA low for the ninth clock.
- R2: A1 and A0 follow the live strap inputs. A2 is the value of its strap input while reset was asserted, and later changes on that strap have no effect.
- R3: After an address that does not match, the slave never drives SDA and acknowledges nothing, and no register changes until the next START or STOP.
- R4: In a write, the first byte after the address is loaded into the pointer and acknowledged. Pointer bit 7 is the auto-increment enable and bits 6:0 are the register index.
- R5: Each later write byte is acknowledged, stored in the register at the pointer index, and pulses the write strobe once. An index at or above NUM_REGS stores nothing, and such a register reads as 0x00.
- R6: With auto-increment set, the 7-bit index advances by one after every byte written or read, and wraps from 127 to 0.
- R7: With auto-increment clear, the index stays fixed across successive bytes.
- R8: Read bytes are sampled from the selected register when the byte begins and are shifted out MSB first. SDA changes only while SCL is low. The slave keeps sending while the master ACKs (SDA low), and after a master NACK (SDA high) it releases SDA.
- R9: A repeated START restarts address reception. STOP returns the slave to idle. The pointer keeps its value across transactions.
- R10: After reset, SDA is released, every register reads 0x00 and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock from the pad |
| sda_i | input | 1 | Bus data from the pad |
| sda_o | output | 1 | Data driven onto SDA, always low |
| sda_oe_o | output | 1 | Enable for pulling SDA low |
| strap_a2_i | input | 1 | Address bit 2 strap, sampled during reset |
| strap_a1_i | input | 1 | Address bit 1 strap |
| strap_a0_i | input | 1 | Address bit 0 strap |
| reg_wr_o | output | 1 | One-cycle pulse per register write |
| reg_idx_o | output | 7 | Register index of the write |
| reg_wdata_o | output | 8 | Data of the write |

## Verification
A wrong pointer or a wrong phase shows up at the latest on the next byte the master reads, as a wrong value on SDA during SCL high. It can also show up earlier, as a wrong count of write strobes. A wrong address match or a stuck state shows up within one byte as a missing or extra acknowledge. The bench therefore keeps a register and pointer model, checks every ACK bit and every received byte against that model, and watches the output enable on every clock for a change while SCL is high.

// File: rtl/i2c_regport_pkg.sv
`timescale 1ns/1ps
package i2c_regport_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned IDX_W  = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXW,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_MACKW,
      ST_SKIP
   } slv_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_PTR,
      PH_DATA
   } slv_phase_t;
endpackage

// File: rtl/i2c_regport_sync.sv
`timescale 1ns/1ps
module i2c_regport_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("i2c_regport_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_pipe;
   logic [SYNC_STAGES-1:0] sda_pipe;
   logic                   scl_d;
   logic                   sda_d;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[0] <= 1'b1;
               sda_pipe[0] <= 1'b1;
            end else begin
               scl_pipe[0] <= scl_i;
               sda_pipe[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[g] <= 1'b1;
               sda_pipe[g] <= 1'b1;
            end else begin
               scl_pipe[g] <= scl_pipe[g-1];
               sda_pipe[g] <= sda_pipe[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_pipe[SYNC_STAGES-1];
         sda_d <= sda_pipe[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[SYNC_STAGES-1];
   assign sda_s     = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

   // R9: bus conditions and clock edges never coincide
   assert_cond_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, stop_det, scl_rise, scl_fall}));
endmodule

// File: rtl/i2c_regport_rf.sv
`timescale 1ns/1ps
module i2c_regport_rf
   import i2c_regport_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BYTE_W-1:0] rd_data
);
   if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_depth
      $error("i2c_regport_rf: NUM_REGS out of range");
   end

   logic [BYTE_W-1:0] mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_idx == IDX_W'(i)) mem[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = mem[i];
      end
   end
endmodule

// File: rtl/i2c_regport.sv
`timescale 1ns/1ps
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  ADDR_HI     = 4'b0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              sda_oe_o,
   input  logic              strap_a2_i,
   input  logic              strap_a1_i,
   input  logic              strap_a0_i,
   output logic              reg_wr_o,
   output logic [IDX_W-1:0]  reg_idx_o,
   output logic [BYTE_W-1:0] reg_wdata_o
);
   if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs
      $error("i2c_regport: NUM_REGS out of range");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_regport_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // upper strap bit captured only while reset is held
   logic a2_q;
   always_ff @(posedge clk) begin
      if (!rst_n) a2_q <= strap_a2_i;
   end

   logic [6:0] dev_addr;
   assign dev_addr = {ADDR_HI, a2_q, strap_a1_i, strap_a0_i};

   slv_state_t          state_q;
   slv_phase_t          phase_q;
   logic                rw_q;
   logic [2:0]          bitcnt_q;
   logic [BYTE_W-1:0]   shreg_q;
   logic [BYTE_W-2:0]   txreg_q;
   logic [BYTE_W-1:0]   ptr_q;
   logic                oe_q;
   logic                wr_q;
   logic [IDX_W-1:0]    wr_idx_q;
   logic [BYTE_W-1:0]   wr_data_q;
   logic [BYTE_W-1:0]   rd_data;
   logic [IDX_W-1:0]    idx_inc;

   assign idx_inc = ptr_q[IDX_W-1:0] + 7'd1;

   i2c_regport_rf #(.NUM_REGS(NUM_REGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_q),
      .wr_idx  (wr_idx_q),
      .wr_data (wr_data_q),
      .rd_idx  (ptr_q[IDX_W-1:0]),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         phase_q   <= PH_ADDR;
         rw_q      <= 1'b0;
         bitcnt_q  <= '0;
         shreg_q   <= '0;
         txreg_q   <= '0;
         ptr_q     <= '0;
         oe_q      <= 1'b0;
         wr_q      <= 1'b0;
         wr_idx_q  <= '0;
         wr_data_q <= '0;
      end else begin
         wr_q <= 1'b0;
         if (start_det) begin
            state_q  <= ST_RX;
            phase_q  <= PH_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
         end else if (stop_det) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                     bitcnt_q <= bitcnt_q + 3'd1;
                     if (bitcnt_q == 3'd7) state_q <= ST_RXW;
                  end
               end
               ST_RXW: begin
                  if (scl_fall) begin
                     case (phase_q)
                        PH_ADDR: begin
                           if (shreg_q[7:1] == dev_addr) begin
                              oe_q    <= 1'b1;
                              rw_q    <= shreg_q[0];
                              phase_q <= shreg_q[0] ? PH_DATA : PH_PTR;
                              state_q <= ST_ACK;
                           end else begin
                              state_q <= ST_SKIP;
                           end
                        end
                        PH_PTR: begin
                           ptr_q   <= shreg_q;
                           oe_q    <= 1'b1;
                           phase_q <= PH_DATA;
                           state_q <= ST_ACK;
                        end
                        default: begin
                           wr_q      <= 1'b1;
                           wr_idx_q  <= ptr_q[IDX_W-1:0];
                           wr_data_q <= shreg_q;
                           if (ptr_q[7]) ptr_q[IDX_W-1:0] <= idx_inc;
                           oe_q    <= 1'b1;
                           state_q <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt_q <= '0;
                     if (rw_q) begin
                        txreg_q <= rd_data[BYTE_W-2:0];
                        oe_q    <= ~rd_data[BYTE_W-1];
                        state_q <= ST_TX;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt_q == 3'd7) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_MACK;
                        if (ptr_q[7]) ptr_q[IDX_W-1:0] <= idx_inc;
                     end else begin
                        txreg_q  <= {txreg_q[BYTE_W-3:0], 1'b0};
                        oe_q     <= ~txreg_q[BYTE_W-2];
                        bitcnt_q <= bitcnt_q + 3'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) state_q <= sda_s ? ST_SKIP : ST_MACKW;
               end
               ST_MACKW: begin
                  if (scl_fall) begin
                     bitcnt_q <= '0;
                     txreg_q  <= rd_data[BYTE_W-2:0];
                     oe_q     <= ~rd_data[BYTE_W-1];
                     state_q  <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_o       = 1'b0;
   assign sda_oe_o    = oe_q;
   assign reg_wr_o    = wr_q;
   assign reg_idx_o   = wr_idx_q;
   assign reg_wdata_o = wr_data_q;

   // R2: latched strap bit stays put outside reset
   assert_a2_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(a2_q));

   // R3: no drive while ignoring the bus or idle
   assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP || state_q == ST_IDLE) |-> !sda_oe_o);

   // R6: pointer has moved one past the strobed index
   assert_autoinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_o && ptr_q[7]) |-> (ptr_q[IDX_W-1:0] == reg_idx_o + 7'd1));

   // R7: pointer still equals the strobed index
   assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_o && !ptr_q[7]) |-> (ptr_q[IDX_W-1:0] == reg_idx_o));

   // R8: SDA enable moves only while SCL is low, or on a bus condition
   assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));
endmodule

// File: tb/i2c_regport_bench.sv
`timescale 1ns/1ps
module i2c_regport_bench;
   localparam int NREG = 16;
   localparam int Q    = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl   = 1'b1;
   logic       sda_m = 1'b1;
   logic       st_a2 = 1'b1;
   logic       st_a1 = 1'b1;
   logic       st_a0 = 1'b0;
   logic       sda_o, sda_oe, reg_wr;
   logic [6:0] reg_idx;
   logic [7:0] reg_wdata;
   logic       sda_bus;

   assign sda_bus = sda_m & ~(sda_oe & ~sda_o);

   i2c_regport #(.NUM_REGS(NREG)) u_i2c_regport (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .sda_o       (sda_o),
      .sda_oe_o    (sda_oe),
      .strap_a2_i  (st_a2),
      .strap_a1_i  (st_a1),
      .strap_a0_i  (st_a0),
      .reg_wr_o    (reg_wr),
      .reg_idx_o   (reg_idx),
      .reg_wdata_o (reg_wdata)
   );

   int checks = 0;
   int errors = 0;
   int wr_seen = 0;
   int exp_wr = 0;
   int bad_oe = 0;
   bit done = 1'b0;
   logic oe_prev = 1'b0;

   // reference model
   logic [7:0] mregs [128];
   logic [7:0] mptr;

   always @(posedge clk) if (rst_n && reg_wr) wr_seen++;

   always @(negedge clk) begin
      if (rst_n && (sda_oe !== oe_prev) && scl === 1'b1) bad_oe++;
      oe_prev = sda_oe;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b0; wq();
      scl = 1'b0;   wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wq();
      scl = 1'b1; wq();
      b = sda_bus; wq();
      scl = 1'b0; wq();
   endtask

   task automatic wr_byte(input logic [7:0] d, output bit ack);
      logic x;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(x);
      ack = !x;
   endtask

   task automatic rd_byte(input bit last, output logic [7:0] d);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         bit_in(x);
         d[i] = x;
      end
      bit_out(last);
   endtask

   task automatic addr_phase(input logic [6:0] a, input bit rd, input bit exp_ack, input string tag);
      bit ack;
      bus_start();
      wr_byte({a, rd}, ack);
      chk(ack == exp_ack, tag, ack, exp_ack);
   endtask

   task automatic send_ptr(input logic [7:0] p);
      bit ack;
      wr_byte(p, ack);
      chk(ack, "R4", ack, 1);
      mptr = p;
   endtask

   task automatic send_data(input logic [7:0] d, input string tag);
      bit ack;
      wr_byte(d, ack);
      chk(ack, tag, ack, 1);
      if (int'(mptr[6:0]) < NREG) mregs[mptr[6:0]] = d;
      exp_wr++;
      if (mptr[7]) mptr[6:0] = mptr[6:0] + 7'd1;
   endtask

   task automatic recv_data(input bit last, input string tag);
      logic [7:0] got, exp;
      rd_byte(last, got);
      exp = (int'(mptr[6:0]) < NREG) ? mregs[mptr[6:0]] : 8'h00;
      chk(got == exp, tag, got, exp);
      if (mptr[7]) mptr[6:0] = mptr[6:0] + 7'd1;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      bit ack;
      for (int i = 0; i < 128; i++) mregs[i] = 8'h00;
      mptr = 8'h00;
      repeat (10) @(posedge clk);
      #1;
      rst_n = 1'b1;
      st_a2 = 1'b0;               // later strap change must be ignored
      wq();
      chk(sda_oe == 1'b0, "R10", sda_oe, 0);
      chk(reg_wr == 1'b0, "R10", reg_wr, 0);

      // write three bytes with auto-increment from index 0
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h80);
      send_data(8'hA5, "R5");
      send_data(8'h3C, "R5");
      send_data(8'hF0, "R6");
      bus_stop();

      // fixed pointer read via repeated start
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h01);
      addr_phase(7'h16, 1'b1, 1'b1, "R9");
      recv_data(1'b0, "R7");
      recv_data(1'b0, "R7");
      recv_data(1'b1, "R8");
      bus_stop();

      // auto-increment read
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h80);
      addr_phase(7'h16, 1'b1, 1'b1, "R9");
      recv_data(1'b0, "R6");
      recv_data(1'b0, "R6");
      recv_data(1'b1, "R6");
      bus_stop();

      // pointer retained across STOP; untouched register reads zero
      addr_phase(7'h16, 1'b1, 1'b1, "R9");
      recv_data(1'b1, "R10");
      wq();
      chk(sda_oe == 1'b0, "R8", sda_oe, 0);
      bus_stop();

      // other address: no ack, no writes
      addr_phase(7'h12, 1'b0, 1'b0, "R3");
      wr_byte(8'h80, ack);
      chk(!ack, "R3", ack, 0);
      wr_byte(8'h77, ack);
      chk(!ack, "R3", ack, 0);
      bus_stop();
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h00);
      addr_phase(7'h16, 1'b1, 1'b1, "R3");
      recv_data(1'b1, "R3");
      bus_stop();

      // live low straps
      st_a1 = 1'b0;
      addr_phase(7'h14, 1'b0, 1'b1, "R2");
      send_ptr(8'h85);
      send_data(8'h11, "R5");
      bus_stop();
      st_a1 = 1'b1;
      addr_phase(7'h14, 1'b0, 1'b0, "R2");
      bus_stop();

      // index beyond the file
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h20);
      send_data(8'h99, "R5");
      addr_phase(7'h16, 1'b1, 1'b1, "R9");
      recv_data(1'b1, "R5");
      bus_stop();

      // wrap from 127 to 0
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'hFF);
      send_data(8'h11, "R5");
      send_data(8'h42, "R6");
      bus_stop();
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h00);
      addr_phase(7'h16, 1'b1, 1'b1, "R9");
      recv_data(1'b1, "R6");
      bus_stop();

      // fixed pointer writes overwrite one register
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h04);
      send_data(8'h01, "R7");
      send_data(8'h02, "R7");
      send_data(8'h03, "R7");
      addr_phase(7'h16, 1'b1, 1'b1, "R9");
      recv_data(1'b0, "R7");
      recv_data(1'b1, "R7");
      bus_stop();
      addr_phase(7'h16, 1'b0, 1'b1, "R1");
      send_ptr(8'h05);
      addr_phase(7'h16, 1'b1, 1'b1, "R9");
      recv_data(1'b1, "R7");
      bus_stop();

      wq();
      chk(wr_seen == exp_wr, "R5", wr_seen, exp_wr);
      chk(bad_oe == 0, "R8", bad_oe, 0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule